// File: doc/BRIEF.md
# Two-Source Serial Frame Merger

The block interleaves two single-bit serial sources, a left one and a right one, onto a single serial output. Everything runs on one bit clock that ticks a fixed number of times per frame (64 by default). A free-running frame counter divides that clock down. Its top bit decides which source is routed to the output, and it is also presented as the frame (word-select) signal. The left source fills the first half of every frame and the right source fills the second half.

Each source gets a shift-enable strobe, and only the source currently routed to the output receives it. The idle source is therefore never advanced during its idle half. The strobes are clock enables in the bit-clock domain, not gated or divided clocks, so the attached shift logic stays fully synchronous.

A parameter adds an output flip-flop that retimes the merged bit by one bit clock. The frame signal and the strobes are not delayed by it. A synchronous reset returns the counter to the start of a left half.

Top module: `dual_serial_merger`

## Requirements
- R1: While `rst` is high at a rising edge, and in the cycle after that edge, `frame_sel` is 0, `left_shift_en` is 1 and `right_shift_en` is 0.
- R2: After reset is released, `frame_sel` is 0 for exactly `FRAME_BITS/2` consecutive cycles, then 1 for exactly `FRAME_BITS/2` cycles, and the pattern repeats without a gap.
- R3: `left_shift_en` is 1 exactly when `frame_sel` is 0. `right_shift_en` is 1 exactly when `frame_sel` is 1. The two strobes are never high together.
- R4: In every frame, each shift strobe is high for exactly `FRAME_BITS/2` consecutive cycles: left in the first half, right in the second.
- R5: With `RETIME` = 0, in each cycle `ser_dout` equals `left_din` when `frame_sel` is 0 and equals `right_din` when `frame_sel` is 1, in the same cycle.
- R6: With `RETIME` = 1, `ser_dout` in each cycle equals the input that was selected in the previous cycle (left when `frame_sel` was 0, right when it was 1).
- R7: The input of the idle source has no effect on `ser_dout`. This holds for `right_din` during the left half and for `left_din` during the right half.
- R8: Asserting `rst` in the middle of a frame restarts the frame. The first cycle after release begins a full left half.
- R9: With `RETIME` = 1, `ser_dout` is 0 in the cycle after any rising edge at which `rst` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, `FRAME_BITS` cycles per frame |
| rst | input | 1 | Synchronous active-high reset |
| left_din | input | 1 | Serial data from the left source |
| right_din | input | 1 | Serial data from the right source |
| ser_dout | output | 1 | Merged serial data |
| frame_sel | output | 1 | Frame signal: 0 = left half, 1 = right half |
| left_shift_en | output | 1 | Shift-clock enable for the left source |
| right_shift_en | output | 1 | Shift-clock enable for the right source |

## Verification
The frame signal and both strobes come straight from the counter register, so they change one edge after the counter steps. The bench drives inputs and samples outputs at the falling edge of the phase it is modelling. With `RETIME` = 0 the merged bit follows the inputs in the same cycle, so it is compared a moment after the inputs are driven. With `RETIME` = 1 it is due one bit clock later, so the bench compares it against the bit it expected in the previous phase, and against 0 in the first phase after reset. Both variants run side by side on the same stimulus, and the idle input always carries the complement of the expected bit, so any leak from the idle source shows up as a mismatch.

// File: rtl/merge_pkg.sv
package merge_pkg;

  // Which source currently owns the output slot
  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;

  // Strobe pair handed to the two serial sources
  typedef struct packed {
    logic left_en;
    logic right_en;
  } shift_en_t;

  function automatic shift_en_t enables_for(side_e s);
    shift_en_t e;
    e.left_en  = (s == SIDE_LEFT);
    e.right_en = (s == SIDE_RIGHT);
    return e;
  endfunction

endpackage

// File: rtl/merge_frame_counter.sv
module merge_frame_counter
  import merge_pkg::*;
#(
  parameter int FRAME_BITS = 64,
  localparam int CW = $clog2(FRAME_BITS)
) (
  input  logic  clk,
  input  logic  rst,
  output side_e side
);

  logic [CW-1:0] count_q;

  // Free-running divide-by-FRAME_BITS; wraps naturally for power-of-two sizes
  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else begin
      count_q <= count_q + CW'(1);
    end
  end

  // The top bit is the half-frame indicator
  assign side = side_e'(count_q[CW-1]);

endmodule

// File: rtl/merge_lane_select.sv
module merge_lane_select
  import merge_pkg::*;
(
  input  side_e side,
  input  logic  left_din,
  input  logic  right_din,
  output logic  mux_bit,
  output logic  left_en,
  output logic  right_en
);

  shift_en_t en;

  always_comb begin
    en = enables_for(side);
    unique case (side)
      SIDE_LEFT:  mux_bit = left_din;
      SIDE_RIGHT: mux_bit = right_din;
      default:    mux_bit = 1'b0;
    endcase
  end

  assign left_en  = en.left_en;
  assign right_en = en.right_en;

endmodule

// File: rtl/merge_retime.sv
module merge_retime (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else begin
      q <= d;
    end
  end

endmodule

// File: rtl/dual_serial_merger.sv
module dual_serial_merger
  import merge_pkg::*;
#(
  parameter int FRAME_BITS = 64,
  parameter bit RETIME     = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic left_din,
  input  logic right_din,
  output logic ser_dout,
  output logic frame_sel,
  output logic left_shift_en,
  output logic right_shift_en
);

  side_e side;
  logic  mux_bit;

  merge_frame_counter #(.FRAME_BITS(FRAME_BITS)) u_counter (
    .clk  (clk),
    .rst  (rst),
    .side (side)
  );

  merge_lane_select u_select (
    .side      (side),
    .left_din  (left_din),
    .right_din (right_din),
    .mux_bit   (mux_bit),
    .left_en   (left_shift_en),
    .right_en  (right_shift_en)
  );

  assign frame_sel = (side == SIDE_RIGHT);

  generate
    if (RETIME) begin : g_retime
      merge_retime u_retime (
        .clk (clk),
        .rst (rst),
        .d   (mux_bit),
        .q   (ser_dout)
      );
    end else begin : g_direct
      assign ser_dout = mux_bit;
    end
  endgenerate

endmodule

// File: rtl/dual_serial_merger_chk.sv
module dual_serial_merger_chk #(
  parameter int FRAME_BITS = 64,
  parameter bit RETIME     = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic left_din,
  input logic right_din,
  input logic ser_dout,
  input logic frame_sel,
  input logic left_shift_en,
  input logic right_shift_en
);

  localparam int HALF = FRAME_BITS / 2;
  localparam int RW   = $clog2(FRAME_BITS) + 1;
  localparam logic [RW-1:0] HALF_L = RW'(HALF);

  logic          fs_q;
  logic [RW-1:0] run_q;

  // Length of the current run of equal frame_sel samples
  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q  <= 1'b0;
      run_q <= '0;
    end else begin
      fs_q  <= frame_sel;
      run_q <= (frame_sel == fs_q) ? run_q + RW'(1) : RW'(1);
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (!frame_sel && left_shift_en && !right_shift_en));

  // R2
  half_len_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_sel != fs_q) |-> (run_q == HALF_L));

  // R2
  half_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_sel == fs_q) |-> (run_q < HALF_L));

  // R3
  strobe_map_chk: assert property (@(posedge clk) disable iff (rst)
    (left_shift_en == !frame_sel) && (right_shift_en == frame_sel));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot({left_shift_en, right_shift_en}));

  generate
    if (RETIME) begin : g_rt
      // R6
      retimed_data_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (ser_dout == ($past(frame_sel) ? $past(right_din) : $past(left_din))));
      // R9
      retime_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (ser_dout == 1'b0));
    end else begin : g_cb
      // R5
      direct_data_chk: assert property (@(posedge clk) disable iff (rst)
        ser_dout == (frame_sel ? right_din : left_din));
    end
  endgenerate

endmodule

bind dual_serial_merger dual_serial_merger_chk #(
  .FRAME_BITS (FRAME_BITS),
  .RETIME     (RETIME)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .left_din       (left_din),
  .right_din      (right_din),
  .ser_dout       (ser_dout),
  .frame_sel      (frame_sel),
  .left_shift_en  (left_shift_en),
  .right_shift_en (right_shift_en)
);

// File: tb/dual_serial_merger_bench.sv
`timescale 1ns/100ps
module dual_serial_merger_bench;

  localparam int FRAME = 64;
  localparam int HALF  = 32;
  localparam int NVEC  = 6;

  // Each entry: {left word, right word}, sent MSB first
  localparam logic [63:0] VEC [NVEC] = '{
    64'hA5A5_0F0F_3C3C_FFFF,
    64'h0000_0000_FFFF_FFFF,
    64'hFFFF_FFFF_0000_0000,
    64'h8000_0001_7FFF_FFFE,
    64'h1234_5678_9ABC_DEF0,
    64'hDEAD_BEEF_0BAD_F00D
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic left_din = 1'b0;
  logic right_din = 1'b0;
  logic dout_rt, fs_rt, len_rt, ren_rt;
  logic dout_cb, fs_cb, len_cb, ren_cb;

  int checks = 0;
  int fails  = 0;
  logic exp_prev = 1'b0;

  always #2.5 clk = ~clk;

  dual_serial_merger #(.FRAME_BITS(FRAME), .RETIME(1'b1)) u_dual_serial_merger (
    .clk(clk), .rst(rst), .left_din(left_din), .right_din(right_din),
    .ser_dout(dout_rt), .frame_sel(fs_rt),
    .left_shift_en(len_rt), .right_shift_en(ren_rt)
  );

  dual_serial_merger #(.FRAME_BITS(FRAME), .RETIME(1'b0)) u_dual_serial_merger_comb (
    .clk(clk), .rst(rst), .left_din(left_din), .right_din(right_din),
    .ser_dout(dout_cb), .frame_sel(fs_cb),
    .left_shift_en(len_cb), .right_shift_en(ren_cb)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Runs ncyc phases of one frame starting at phase 0; the caller is just past
  // the rising edge that precedes phase 0.
  task automatic run_frame(input logic [63:0] v, input int ncyc);
    for (int c = 0; c < ncyc; c++) begin
      logic right_half;
      logic exp_bit;
      @(negedge clk);
      right_half = (c >= HALF);
      exp_bit = right_half ? v[HALF-1-(c-HALF)] : v[63-c];
      // idle input carries the complement so any leak is visible (R7)
      left_din  = right_half ? ~exp_bit : exp_bit;
      right_din = right_half ? exp_bit : ~exp_bit;
      #1;
      check("R2 frame_sel", fs_rt, right_half);
      check("R2 frame_sel comb", fs_cb, right_half);
      check("R3 left strobe", len_rt, !right_half);
      check("R4 right strobe", ren_rt, right_half);
      check("R4 comb strobes", len_cb ^ ren_cb, 1'b1);
      if (right_half) check("R7 idle left ignored", dout_cb, exp_bit);
      else            check("R5 direct data", dout_cb, exp_bit);
      check("R6 retimed data", dout_rt, exp_prev);
      exp_prev = exp_bit;
    end
  endtask

  task automatic reset_pulse(input string tag);
    @(negedge clk);
    rst = 1'b1;
    left_din  = 1'b1;
    right_din = 1'b1;
    @(negedge clk);
    check({tag, " R1 frame_sel in reset"}, fs_rt, 1'b0);
    check({tag, " R1 left strobe in reset"}, len_rt, 1'b1);
    check({tag, " R1 right strobe in reset"}, ren_rt, 1'b0);
    check({tag, " R9 retime cleared"}, dout_rt, 1'b0);
    @(posedge clk);
    #1 rst = 1'b0;
    exp_prev = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    reset_pulse("R1");
    // table walk: continuous frames, no reset in between
    for (int i = 0; i < NVEC; i++) begin
      run_frame(VEC[i], FRAME);
    end
    // R8: reset in the middle of a left half, then a full fresh frame
    run_frame(64'hFFFF_0000_AAAA_5555, 10);
    reset_pulse("R8");
    run_frame(64'h0F0F_F0F0_CCCC_3333, FRAME);
    // R8: reset in the middle of a right half
    run_frame(64'h5555_AAAA_FFFF_0000, 45);
    reset_pulse("R8");
    run_frame(64'h0001_8000_FFFE_7FFF, FRAME);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule